// File: doc/BRIEF.md
# Half-Duplex Byte SPI Master

This block is a register-mapped SPI master that moves one byte per command and never shifts in both directions at once. Software writes a byte into the data register and sets the write-start bit to send it, or sets the read-start bit and later collects the received byte from that same data register. While a byte is in flight, a busy register reads nonzero. Software polls it before each new start, and after a read it polls again before taking the data.

The chip-select pin and the MOSI output enable follow two software-owned control bits directly. Selecting a device and releasing the output are therefore plain register writes, with no sequencing in hardware. A configuration register sets four things: bit order, idle clock level, the SCLK edge on which the master changes MOSI, and the SCLK edge on which it samples MISO. It also holds a power-of-two divider code that is clamped at its slowest setting.

Top module: `spiByteMaster`

## Requirements
- R1: After reset the outputs and registers hold these values:
  - spiCsN is 1, spiMosiEn is 0 and spiSclk is 0.
  - The busy register (address 3) reads 0, the data register (address 2) reads 0x00 and the control register (address 0) reads 0x0C.
  - The configuration register (address 1) reads 0x0E: MSB first, divider code 6.
- R2: The control register maps its bits as follows:
  - Bit 2 sets the chip-select pin: spiCsN equals the last value written to this bit.
  - Bit 3 is the MOSI release: while it is 1, spiMosiEn is 0; while it is 0, spiMosiEn is 1.
- R3: Writing control bit 0 (write-start) while idle shifts out the byte held in the data register over exactly 8 SCLK cycles. The bit order is MSB first when configuration bit 3 is 1 and LSB first when it is 0. The data register is not changed.
- R4: Writing control bit 1 (read-start) while idle shifts in 8 bits from spiMiso in the configured bit order and then places the byte in the data register. spiMosi stays 0 for the whole read.
- R5: SCLK idles at the level of configuration bit 4. The master changes MOSI on falling SCLK edges when configuration bit 5 is 1, and on rising edges when it is 0. It samples MISO on falling edges when configuration bit 6 is 1, and on rising edges when it is 0. The first bit is on MOSI before the first edge. Each byte makes 16 SCLK edges.
- R6: Each SCLK half period lasts 2^code system clocks, where code is configuration bits 2:0. Codes 7 and above act as code 6. A byte keeps the block busy for 16*2^code+1 clocks.
- R7: The busy register reads 1 from the clock after an accepted start until one clock after the last SCLK edge, and reads 0 otherwise.
- R8: A start that arrives while busy is ignored. This includes a start sampled in the very cycle busy clears. Such a start moves no data and does not extend busy.
- R9: Start bits read back as 0. If both start bits are written at once, the write takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 control, 1 configuration, 2 data, 3 busy |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for regAddr, combinational |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data out |
| spiMosiEn | output | 1 | Output enable for spiMosi; 0 means high impedance |
| spiMiso | input | 1 | Serial data in |
| spiCsN | output | 1 | Chip select, low selects the device |

## Verification
The critical collision is a new start request landing in the same clock in which the previous byte finishes and busy drops. The rule is that such a request is dropped. The bench counts clocks from a known accepted start and places a second control write so that it is sampled exactly 16*2^code+1 clocks later. It then expects busy to stay 0 and the data register to keep its value, and expects a start issued a few clocks afterwards to be accepted.

// File: rtl/spiByteMasterPkg.sv
package spiByteMasterPkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_BUSY = 2'd3;

  // control register bit positions
  localparam int START_WR_BIT = 0;
  localparam int START_RD_BIT = 1;
  localparam int CS_HIGH_BIT  = 2;
  localparam int MOSI_HIZ_BIT = 3;

  // configuration register bit positions, divider code in [2:0]
  localparam int DIV_W        = 3;
  localparam int CFG_MSB_BIT  = 3;
  localparam int CFG_CPOL_BIT = 4;
  localparam int CFG_TXF_BIT  = 5;
  localparam int CFG_CAPF_BIT = 6;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FINISH
  } ctlState_t;

  typedef struct packed {
    logic loadByte;
    logic loadWrite;
    logic shiftTx;
    logic shiftRx;
    logic commitRx;
    logic mosiActive;
    logic msbFirst;
  } dpStrobe_t;

endpackage

// File: rtl/spiByteCtl.sv
module spiByteCtl
  import spiByteMasterPkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int MAX_CODE = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [1:0]            regAddr,
  input  logic [CFG_CAPF_BIT:0] cfgWdata,
  output logic                  busy,
  output logic                  csHigh,
  output logic                  mosiHiz,
  output logic                  sclk,
  output logic [BYTE_W-1:0]     cfgRead,
  output dpStrobe_t             strobes
);

  localparam int EDGE_N = 2 * BYTE_W;
  localparam int EDGE_W = $clog2(EDGE_N);
  localparam int CNT_W  = (MAX_CODE > 0) ? MAX_CODE : 1;
  localparam logic [DIV_W-1:0] MAX_CODE_V = DIV_W'(MAX_CODE);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGE_N - 1);

  ctlState_t         state;
  logic              csHighQ, hizQ, isWriteQ, sclkQ;
  logic [DIV_W-1:0]  divCode;
  logic              msbQ, cpolQ, txFallQ, capFallQ;
  logic [CNT_W-1:0]  divCnt;
  logic [EDGE_W-1:0] edgeCnt;

  logic              wrCtrl, wrCfg, startReq, accept, tick, lastEdge, fallNow;
  logic [DIV_W-1:0]  effCode;
  logic [CNT_W-1:0]  halfLast;

  assign wrCtrl   = regWrEn && (regAddr == ADDR_CTRL);
  assign wrCfg    = regWrEn && (regAddr == ADDR_CFG);
  assign startReq = wrCtrl && (cfgWdata[START_WR_BIT] || cfgWdata[START_RD_BIT]);
  assign accept   = (state == ST_IDLE) && startReq;

  // clamp the divider code, half period is 2^code clocks
  assign effCode  = (divCode > MAX_CODE_V) ? MAX_CODE_V : divCode;
  assign halfLast = CNT_W'((32'd1 << effCode) - 32'd1);
  assign tick     = (state == ST_RUN) && (divCnt == halfLast);
  assign lastEdge = (edgeCnt == LAST_EDGE);
  assign fallNow  = sclkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csHighQ  <= 1'b1;
      hizQ     <= 1'b1;
      divCode  <= MAX_CODE_V;
      msbQ     <= 1'b1;
      cpolQ    <= 1'b0;
      txFallQ  <= 1'b0;
      capFallQ <= 1'b0;
      state    <= ST_IDLE;
      isWriteQ <= 1'b0;
      sclkQ    <= 1'b0;
      divCnt   <= '0;
      edgeCnt  <= '0;
    end else begin
      if (wrCtrl) begin
        csHighQ <= cfgWdata[CS_HIGH_BIT];
        hizQ    <= cfgWdata[MOSI_HIZ_BIT];
      end
      if (wrCfg) begin
        divCode  <= cfgWdata[DIV_W-1:0];
        msbQ     <= cfgWdata[CFG_MSB_BIT];
        cpolQ    <= cfgWdata[CFG_CPOL_BIT];
        txFallQ  <= cfgWdata[CFG_TXF_BIT];
        capFallQ <= cfgWdata[CFG_CAPF_BIT];
      end
      unique case (state)
        ST_IDLE: begin
          sclkQ   <= cpolQ;
          divCnt  <= '0;
          edgeCnt <= '0;
          if (startReq) begin
            state    <= ST_RUN;
            isWriteQ <= cfgWdata[START_WR_BIT];
          end
        end
        ST_RUN: begin
          if (tick) begin
            divCnt  <= '0;
            sclkQ   <= ~sclkQ;
            edgeCnt <= edgeCnt + EDGE_W'(1);
            if (lastEdge) state <= ST_FINISH;
          end else begin
            divCnt <= divCnt + CNT_W'(1);
          end
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.loadByte   = accept;
    strobes.loadWrite  = cfgWdata[START_WR_BIT];
    // no MOSI change on the very first edge: bit 0 must survive it
    strobes.shiftTx    = tick && (fallNow == txFallQ) && (edgeCnt != '0);
    strobes.shiftRx    = tick && (fallNow == capFallQ);
    strobes.commitRx   = (state == ST_FINISH) && !isWriteQ;
    strobes.mosiActive = (state != ST_IDLE) && isWriteQ;
    strobes.msbFirst   = msbQ;
  end

  always_comb begin
    cfgRead               = '0;
    cfgRead[DIV_W-1:0]    = divCode;
    cfgRead[CFG_MSB_BIT]  = msbQ;
    cfgRead[CFG_CPOL_BIT] = cpolQ;
    cfgRead[CFG_TXF_BIT]  = txFallQ;
    cfgRead[CFG_CAPF_BIT] = capFallQ;
  end

  assign busy    = (state != ST_IDLE);
  assign csHigh  = csHighQ;
  assign mosiHiz = hizQ;
  assign sclk    = sclkQ;

endmodule

// File: rtl/spiByteDp.sv
module spiByteDp
  import spiByteMasterPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrData,
  input  logic [BYTE_W-1:0] wdata,
  input  dpStrobe_t         strobes,
  input  logic              miso,
  output logic [BYTE_W-1:0] dataQ,
  output logic              mosi
);

  logic [BYTE_W-1:0] txShift, rxShift, dataR;
  logic              txBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataR   <= '0;
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (strobes.commitRx)  dataR <= rxShift;
      else if (wrData)       dataR <= wdata;

      if (strobes.loadByte) begin
        txShift <= strobes.loadWrite ? dataR : '0;
        rxShift <= '0;
      end else begin
        if (strobes.shiftTx) begin
          if (strobes.msbFirst) txShift <= {txShift[BYTE_W-2:0], 1'b0};
          else                  txShift <= {1'b0, txShift[BYTE_W-1:1]};
        end
        if (strobes.shiftRx) begin
          if (strobes.msbFirst) rxShift <= {rxShift[BYTE_W-2:0], miso};
          else                  rxShift <= {miso, rxShift[BYTE_W-1:1]};
        end
      end
    end
  end

  assign txBit = strobes.msbFirst ? txShift[BYTE_W-1] : txShift[0];
  assign mosi  = strobes.mosiActive && txBit;
  assign dataQ = dataR;

endmodule

// File: rtl/spiByteMaster.sv
module spiByteMaster
  import spiByteMasterPkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int MAX_CODE = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRdata,
  output logic              spiSclk,
  output logic              spiMosi,
  output logic              spiMosiEn,
  input  logic              spiMiso,
  output logic              spiCsN
);

  dpStrobe_t         strobes;
  logic              busy, csHigh, mosiHiz, wrData;
  logic [BYTE_W-1:0] cfgRead, dataQ;

  assign wrData = regWrEn && (regAddr == ADDR_DATA);

  spiByteCtl #(.BYTE_W(BYTE_W), .MAX_CODE(MAX_CODE)) ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .cfgWdata (regWdata[CFG_CAPF_BIT:0]),
    .busy     (busy),
    .csHigh   (csHigh),
    .mosiHiz  (mosiHiz),
    .sclk     (spiSclk),
    .cfgRead  (cfgRead),
    .strobes  (strobes)
  );

  spiByteDp #(.BYTE_W(BYTE_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrData  (wrData),
    .wdata   (regWdata),
    .strobes (strobes),
    .miso    (spiMiso),
    .dataQ   (dataQ),
    .mosi    (spiMosi)
  );

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_CTRL: begin
        regRdata[CS_HIGH_BIT]  = csHigh;
        regRdata[MOSI_HIZ_BIT] = mosiHiz;
      end
      ADDR_CFG:  regRdata = cfgRead;
      ADDR_DATA: regRdata = dataQ;
      ADDR_BUSY: regRdata[0] = busy;
      default:   regRdata = '0;
    endcase
  end

  assign spiCsN    = csHigh;
  assign spiMosiEn = !mosiHiz;

endmodule

// File: rtl/spiByteMasterChk.sv
module spiByteMasterChk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [1:0]        regAddr,
  input logic [3:0]        ctrlWdata,
  input logic              spiCsN,
  input logic              spiMosiEn,
  input logic              spiSclk,
  input logic              busy,
  input logic              cpolLvl,
  input logic [BYTE_W-1:0] dataQ,
  input logic              commitRx
);

  logic wrCtrl, wrData;
  assign wrCtrl = regWrEn && (regAddr == 2'd0);
  assign wrData = regWrEn && (regAddr == 2'd2);

  // R2
  cs_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl |=> (spiCsN == $past(ctrlWdata[2])));

  // R2
  hiz_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && ctrlWdata[3]) |=> !spiMosiEn);

  // R5
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy) && $stable(cpolLvl)) |-> (spiSclk == cpolLvl));

  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && wrCtrl && (ctrlWdata[1:0] != 2'b00)) |=> busy);

  // R4
  data_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataQ) |-> ($past(wrData) || $past(commitRx)));

endmodule

bind spiByteMaster spiByteMasterChk #(.BYTE_W(BYTE_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .ctrlWdata (regWdata[3:0]),
  .spiCsN    (spiCsN),
  .spiMosiEn (spiMosiEn),
  .spiSclk   (spiSclk),
  .busy      (busy),
  .cpolLvl   (cfgRead[4]),
  .dataQ     (dataQ),
  .commitRx  (strobes.commitRx)
);

// File: tb/spiByteMaster_tb_top.sv
`timescale 1ns/1ps
module spiByteMaster_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       spiSclk, spiMosi, spiMosiEn, spiCsN;
  logic       spiMiso = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench mirrors of software state and the slave model
  bit   tbHiz = 1'b1;
  bit   readActive = 1'b0;
  int   hizViol = 0;
  int   readMosiHits = 0;
  bit   slvMsb, slvCapFall, slvTxFall;
  logic [7:0] slvTx, slvRx;
  int   slvEdge = 0;
  logic lastSclk = 1'b0;

  always #2 clk = ~clk;

  spiByteMaster dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .spiSclk(spiSclk),
    .spiMosi(spiMosi), .spiMosiEn(spiMosiEn), .spiMiso(spiMiso),
    .spiCsN(spiCsN)
  );

  // stimulus table: {cfg, byte sent by master, byte returned by slave}
  // cfg: [6] capture falling, [5] transmit falling, [4] idle level, [3] MSB first, [2:0] code
  localparam int NVEC = 8;
  localparam logic [23:0] VEC [NVEC] = '{
    24'h48_A5_3C, 24'h28_96_C3, 24'h5B_81_7E, 24'h3B_5A_01,
    24'h40_01_80, 24'h36_C4_2B, 24'h27_0F_F0, 24'h59_E7_18
  };

  // slave: reacts half a clock after each SCLK edge
  always @(negedge clk) begin
    if (rstN && spiSclk !== lastSclk) begin
      if ((lastSclk == 1'b1) == slvCapFall)
        slvRx = slvMsb ? {slvRx[6:0], spiMosi} : {spiMosi, slvRx[7:1]};
      if (((lastSclk == 1'b1) == slvTxFall) && slvEdge != 0) begin
        slvTx = slvMsb ? {slvTx[6:0], 1'b0} : {1'b0, slvTx[7:1]};
      end
      spiMiso = slvMsb ? slvTx[7] : slvTx[0];
      slvEdge = slvEdge + 1;
    end
    lastSclk = spiSclk;
    if (rstN && tbHiz && spiMosiEn) hizViol++;
    if (readActive && spiMosi) readMosiHits++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk);
    #1;
    if (a == 2'd0) tbHiz = d[3];
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic armSlave(input logic [7:0] cfg, input logic [7:0] b);
    slvMsb = cfg[3]; slvTxFall = cfg[5]; slvCapFall = cfg[6];
    slvTx = b; slvRx = 8'h00; slvEdge = 0;
    spiMiso = cfg[3] ? b[7] : b[0];
  endtask

  // called right after the start write returns; counts busy samples
  task automatic countBusy(output int n);
    logic [7:0] r;
    n = 0;
    regRd(2'd3, r);
    while (r[0] && n < 5000) begin
      n++;
      @(negedge clk);
      regRd(2'd3, r);
    end
  endtask

  initial begin : mainSeq
    logic [7:0] r;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 csN", spiCsN, 1);
    check("R1 mosiEn", spiMosiEn, 0);
    check("R1 sclk", spiSclk, 0);
    regRd(2'd3, r); check("R1 busy", r, 8'h00);
    regRd(2'd1, r); check("R1 cfg", r, 8'h0E);
    regRd(2'd0, r); check("R1 ctrl", r, 8'h0C);
    regRd(2'd2, r); check("R1 data", r, 8'h00);

    // R2 / R9 control readback and pins
    regWr(2'd0, 8'h04);
    regRd(2'd0, r); check("R9 ctrl readback", r, 8'h04);
    check("R2 csN high", spiCsN, 1);
    check("R2 mosiEn on", spiMosiEn, 1);
    regWr(2'd0, 8'h08);
    check("R2 csN low", spiCsN, 0);
    check("R2 mosiEn off", spiMosiEn, 0);

    // table walk: one write and one read per entry
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] cfg, txB, slvB;
      int code, expBusy;
      cfg = VEC[i][23:16]; txB = VEC[i][15:8]; slvB = VEC[i][7:0];
      code = (cfg[2:0] > 3'd6) ? 6 : int'(cfg[2:0]);
      expBusy = 16 * (1 << code) + 1;
      regWr(2'd1, cfg);
      regRd(2'd1, r); check("R6 cfg readback", r, {24'h0, cfg});
      repeat (2) @(negedge clk);
      check("R5 idle level", spiSclk, cfg[4]);
      regWr(2'd2, txB);
      armSlave(cfg, 8'h00);
      regWr(2'd0, 8'h01);
      countBusy(n);
      check("R6 write busy clocks", n, expBusy);
      check("R3 slave got byte", slvRx, txB);
      check("R5 edge count", slvEdge, 16);
      regRd(2'd2, r); check("R3 data kept", r, txB);
      check("R5 idle after write", spiSclk, cfg[4]);
      armSlave(cfg, slvB);
      readActive = 1'b1;
      regWr(2'd0, 8'h02);
      countBusy(n);
      readActive = 1'b0;
      check("R7 read busy clocks", n, expBusy);
      regRd(2'd2, r); check("R4 read byte", r, slvB);
      check("R4 mosi low in read", readMosiHits, 0);
      regWr(2'd0, 8'h0C);
      check("R2 deselect", spiCsN, 1);
    end

    // R9 both start bits: write wins
    regWr(2'd1, 8'h48);
    regWr(2'd2, 8'h6D);
    armSlave(8'h48, 8'hFF);
    regWr(2'd0, 8'h03);
    countBusy(n);
    check("R9 both bits sends", slvRx, 8'h6D);
    regRd(2'd2, r); check("R9 both bits data", r, 8'h6D);

    // R8 start while busy mid-byte
    regWr(2'd2, 8'h5C);
    armSlave(8'h48, 8'hAA);
    regWr(2'd0, 8'h01);
    repeat (3) @(negedge clk);
    regWr(2'd0, 8'h02);
    countBusy(n);
    check("R8 ignored edges", slvEdge, 16);
    check("R8 ignored slave byte", slvRx, 8'h5C);
    regRd(2'd2, r); check("R8 ignored data", r, 8'h5C);

    // R8 start sampled in the cycle busy clears (code 0: 17 busy clocks)
    armSlave(8'h48, 8'h99);
    regWr(2'd0, 8'h01);
    repeat (15) @(negedge clk);
    regWr(2'd0, 8'h02);
    regRd(2'd3, r); check("R8 collide busy", r, 8'h00);
    repeat (5) @(negedge clk);
    regRd(2'd3, r); check("R8 collide stays idle", r, 8'h00);
    regRd(2'd2, r); check("R8 collide data", r, 8'h5C);
    regWr(2'd0, 8'h01);
    regRd(2'd3, r); check("R7 later start busy", r, 8'h01);
    countBusy(n);

    regWr(2'd0, 8'h0C);
    repeat (4) @(negedge clk);
    check("R2 hiz never driven", hizViol, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule